// File: doc/BRIEF.md
# Load/Store Alignment and Endian Unit

This block sits between a core's register file and a 32-bit little-endian memory bus. It takes one access request at a time (byte, halfword, word or doubleword; load or store) and turns it into either an abort or one or two word-aligned bus beats with per-byte lane strobes. For loads it then takes the returned words, merges them if the access crossed a word boundary, puts the bytes into register order and zero- or sign-extends the result.

Three control inputs pick the behaviour for accesses that are not naturally aligned. `cfg_align_chk` turns every misaligned access into an abort. With it clear, `cfg_unal_en` chooses between a legacy mode and a hardware mode. In legacy mode an unaligned word load returns the containing word rotated, and an unaligned word store drops the low address bits. In hardware mode word and halfword accesses at any byte address are split into two beats when they cross a word. `cfg_big_end` reorders bytes between memory and register. Memory byte addresses do not change; only the register lane that each byte lands in changes.

The bus is a simple one: a beat is issued with `bus_valid` and is always taken. Read data for a beat appears on `bus_rdata` in the following cycle. Address generation, caches, translation and abort handling belong to the surrounding core.

Top module: `lsu_align_endian`

## Requirements
- R1: While reset is active, and in the cycles after it until a request arrives, `req_ready` is 1 and `bus_valid` and `resp_valid` are 0.
- R2: With `cfg_align_chk`=1, every misaligned access aborts. A halfword is misaligned when address bit 0 is 1. A word or doubleword is misaligned when address bits [1:0] are non-zero. An aborted access issues no bus beat, writes no memory and reports `resp_abort`=1. Byte accesses never abort.
- R3: In legacy mode (`cfg_align_chk`=0, `cfg_unal_en`=0), a misaligned word load reads the containing word in one beat. It returns that word rotated right by 8×addr[1:0] bits.
- R4: In legacy mode, a misaligned word store writes the word at the containing word address, with strobes 4'b1111 and the data unshifted, as if addr[1:0] were 0.
- R5: A misaligned halfword in legacy mode aborts. A doubleword whose address bits [1:0] are non-zero aborts in every mode.
- R6: With `cfg_unal_en`=1 and `cfg_align_chk`=0, word and halfword loads and stores at any byte address complete. An access that crosses a word boundary issues two beats, at the containing word address and then that address plus 4. A load merges the bytes of both beats.
- R7: Strobe bit i enables bus byte lane i (data bits 8i+7:8i). A store that crosses a word sets only the strobes of the bytes it covers, on each beat.
- R8: With `cfg_big_end`=1, a halfword access swaps its two bytes and a word access reverses its four bytes. A doubleword reverses each 32-bit half; the word at the lower address always maps to register bits [31:0]. Byte accesses are unchanged.
- R9: Byte and halfword loads zero-extend to 32 bits when `req_signed`=0 and sign-extend when it is 1. The extension uses the top bit after byte reordering. `req_size` is coded 0 for byte, 1 for halfword, 2 for word and 3 for doubleword.
- R10: The first beat is issued in the cycle after the request is accepted, and a second beat follows in the next cycle. `resp_valid` is high for exactly one cycle: the cycle after the last beat, or the cycle after acceptance for an abort. `req_ready` is high only when the unit is idle.
- R11: An aligned access uses one beat at the word address. Its byte occupies lane addr[1:0], a halfword occupies lanes addr[1]×2 and addr[1]×2+1, and a word occupies all four lanes. `resp_data` bits [63:32] are 0 unless the access is a doubleword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_store | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_signed | input | 1 | Sign-extend byte/halfword loads |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store data in register order |
| cfg_align_chk | input | 1 | Abort on any misaligned access |
| cfg_unal_en | input | 1 | Hardware unaligned word/halfword support |
| cfg_big_end | input | 1 | Big-endian byte order for data |
| bus_valid | output | 1 | Bus beat issued |
| bus_write | output | 1 | Beat is a write |
| bus_addr | output | ADDR_W | Word-aligned beat address |
| bus_strb | output | 4 | Byte lane enables |
| bus_wdata | output | 32 | Write data by lane |
| bus_rdata | input | 32 | Read data, one cycle after the beat |
| resp_valid | output | 1 | Access finished |
| resp_abort | output | 1 | Access was aborted |
| resp_data | output | 64 | Load result in register order |

## Verification
The bench targets the points where the three control bits meet: a misaligned word in legacy mode, in hardware mode and under alignment checking. Mixing these up shows as a rotated value where merged bytes were due, a second beat where none was due, or a missing abort. Word-crossing loads and stores are checked beat by beat. A wrong second address or a strobe on an untouched lane shows up as a corrupted neighbouring byte when the memory is read back. A big-endian halfword is loaded with opposite sign bits in its two bytes, so that extending before the swap gives the wrong upper half. Doubleword big-endian loads catch a design that swaps the two words as well as their bytes.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int LANES     = 4;
  localparam int MAX_BEATS = 2;
  localparam int WIN_BYTES = LANES * MAX_BEATS;
  localparam int WIN_BITS  = WIN_BYTES * 8;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_HALF  = 2'd1;
  localparam logic [1:0] SZ_WORD  = 2'd2;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BEAT_A = 2'd1,
    ST_BEAT_B = 2'd2,
    ST_RESP   = 2'd3
  } lsu_state_e;

  function automatic logic [WIN_BYTES-1:0] size_lanes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_lanes = 8'h01;
      SZ_HALF: size_lanes = 8'h03;
      SZ_WORD: size_lanes = 8'h0F;
      default: size_lanes = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [1:0]           size,
  input  logic [1:0]           off,
  input  logic                 align_chk,
  input  logic                 unal_en,
  output logic                 abort,
  output logic [1:0]           place_off,
  output logic [WIN_BYTES-1:0] lanes
);
  logic misaligned;
  logic legacy_word;

  always_comb begin
    case (size)
      SZ_HALF: misaligned = off[0];
      SZ_WORD,
      SZ_DWORD: misaligned = |off;
      default: misaligned = 1'b0;
    endcase
  end

  assign abort = misaligned &
                 (align_chk | (size == SZ_DWORD) | (!unal_en && size == SZ_HALF));
  assign legacy_word = misaligned & !align_chk & !unal_en & (size == SZ_WORD);
  assign place_off   = legacy_word ? 2'd0 : off;
  assign lanes       = abort ? '0 : (size_lanes(size) << place_off);
endmodule

// File: rtl/lsu_byte_order.sv
module lsu_byte_order
  import lsu_pkg::*;
(
  input  logic [1:0]          size,
  input  logic                big,
  input  logic [WIN_BITS-1:0] din,
  output logic [WIN_BITS-1:0] dout
);
  for (genvar w = 0; w < MAX_BEATS; w++) begin : g_word
    logic [31:0] wi;
    logic [31:0] rev;
    logic [31:0] hsw;
    assign wi  = din[32*w +: 32];
    for (genvar b = 0; b < LANES; b++) begin : g_rev
      assign rev[8*b +: 8] = wi[8*(LANES-1-b) +: 8];
    end
    assign hsw = {wi[31:16], wi[7:0], wi[15:8]};
    always_comb begin
      if (!big || size == SZ_BYTE) dout[32*w +: 32] = wi;
      else if (size == SZ_HALF)    dout[32*w +: 32] = hsw;
      else                         dout[32*w +: 32] = rev;
    end
  end
endmodule

// File: rtl/lsu_load_lanes.sv
module lsu_load_lanes
  import lsu_pkg::*;
(
  input  logic [31:0]         first_word,
  input  logic [31:0]         cur_word,
  input  logic                two_beats,
  input  logic [1:0]          off,
  input  logic [1:0]          size,
  input  logic                sgn,
  input  logic                big,
  output logic [WIN_BITS-1:0] data
);
  logic [WIN_BITS-1:0] win;
  logic [WIN_BITS-1:0] raw;
  logic [WIN_BITS-1:0] ord;

  // single beat: both halves are the same word, so the shift is a rotate
  assign win = {cur_word, (two_beats ? first_word : cur_word)};
  assign raw = win >> {off, 3'b000};

  lsu_byte_order u_order (
    .size (size),
    .big  (big),
    .din  (raw),
    .dout (ord)
  );

  always_comb begin
    case (size)
      SZ_BYTE: data = {32'd0, {24{sgn & ord[7]}}, ord[7:0]};
      SZ_HALF: data = {32'd0, {16{sgn & ord[15]}}, ord[15:0]};
      SZ_WORD: data = {32'd0, ord[31:0]};
      default: data = ord;
    endcase
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
(
  input  logic [WIN_BITS-1:0] wdata,
  input  logic [1:0]          size,
  input  logic                big,
  input  logic [1:0]          place_off,
  output logic [WIN_BITS-1:0] win_data
);
  logic [WIN_BITS-1:0]  ord;
  logic [WIN_BITS-1:0]  keep;
  logic [WIN_BYTES-1:0] bmask;

  lsu_byte_order u_order (
    .size (size),
    .big  (big),
    .din  (wdata),
    .dout (ord)
  );

  assign bmask = size_lanes(size);
  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_keep
    assign keep[8*b +: 8] = {8{bmask[b]}};
  end

  assign win_data = (ord & keep) << {place_off, 3'b000};
endmodule

// File: rtl/lsu_align_endian.sv
module lsu_align_endian
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_store,
  input  logic [1:0]          req_size,
  input  logic                req_signed,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [63:0]         req_wdata,
  input  logic                cfg_align_chk,
  input  logic                cfg_unal_en,
  input  logic                cfg_big_end,
  output logic                bus_valid,
  output logic                bus_write,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [3:0]          bus_strb,
  output logic [31:0]         bus_wdata,
  input  logic [31:0]         bus_rdata,
  output logic                resp_valid,
  output logic                resp_abort,
  output logic [63:0]         resp_data
);
  localparam int WORD_AW = ADDR_W - 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_q_n  <= rst_s1_n;
    end
  end

  lsu_state_e state_q, state_d;
  logic                 r_store, r_sgn, r_big, r_abort;
  logic [1:0]           r_size, r_off, r_place;
  logic [WIN_BYTES-1:0] r_lanes;
  logic [WORD_AW-1:0]   r_word;
  logic [63:0]          r_wdata;
  logic [31:0]          r_first;

  logic                 dec_abort;
  logic [1:0]           dec_place;
  logic [WIN_BYTES-1:0] dec_lanes;
  logic                 accept, first_en, two_beats, in_b;
  logic [WIN_BITS-1:0]  st_win, ld_data;

  lsu_decode u_decode (
    .size      (req_size),
    .off       (req_addr[1:0]),
    .align_chk (cfg_align_chk),
    .unal_en   (cfg_unal_en),
    .abort     (dec_abort),
    .place_off (dec_place),
    .lanes     (dec_lanes)
  );

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign first_en  = (state_q == ST_BEAT_B);
  assign two_beats = |r_lanes[WIN_BYTES-1:LANES];
  assign in_b      = (state_q == ST_BEAT_B);

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req_valid) state_d = dec_abort ? ST_RESP : ST_BEAT_A;
      ST_BEAT_A: state_d = two_beats ? ST_BEAT_B : ST_RESP;
      ST_BEAT_B: state_d = ST_RESP;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      r_store <= 1'b0;
      r_sgn   <= 1'b0;
      r_big   <= 1'b0;
      r_abort <= 1'b0;
      r_size  <= SZ_BYTE;
      r_off   <= 2'd0;
      r_place <= 2'd0;
      r_lanes <= '0;
      r_word  <= '0;
      r_wdata <= '0;
    end else if (accept) begin
      r_store <= req_store;
      r_sgn   <= req_signed;
      r_big   <= cfg_big_end;
      r_abort <= dec_abort;
      r_size  <= req_size;
      r_off   <= req_addr[1:0];
      r_place <= dec_place;
      r_lanes <= dec_lanes;
      r_word  <= req_addr[ADDR_W-1:2];
      r_wdata <= req_wdata;
    end
  end

  // first-beat read data, enabled while the second beat is out
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)      r_first <= '0;
    else if (first_en) r_first <= bus_rdata;
  end

  lsu_store_lanes u_store (
    .wdata     (r_wdata),
    .size      (r_size),
    .big       (r_big),
    .place_off (r_place),
    .win_data  (st_win)
  );

  lsu_load_lanes u_load (
    .first_word (r_first),
    .cur_word   (bus_rdata),
    .two_beats  (two_beats),
    .off        (r_off),
    .size       (r_size),
    .sgn        (r_sgn),
    .big        (r_big),
    .data       (ld_data)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign bus_valid  = (state_q == ST_BEAT_A) || in_b;
  assign bus_write  = bus_valid && r_store;
  assign bus_addr   = {r_word + WORD_AW'(in_b), 2'b00};
  assign bus_strb   = in_b ? r_lanes[WIN_BYTES-1:LANES] : r_lanes[LANES-1:0];
  assign bus_wdata  = in_b ? st_win[WIN_BITS-1:32] : st_win[31:0];
  assign resp_valid = (state_q == ST_RESP);
  assign resp_abort = resp_valid && r_abort;
  assign resp_data  = (resp_valid && !r_abort && !r_store) ? ld_data : '0;

  // checks
  AST_ABORT_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_q_n)
    resp_abort |-> (!bus_valid && !$past(bus_valid))); // R2
  AST_BEAT_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_q_n)
    bus_valid |-> (bus_strb != 4'd0)); // R7
  AST_SECOND_BEAT_NEXT_WORD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_valid && $past(bus_valid)) |-> (bus_addr == $past(bus_addr) + ADDR_W'(4))); // R6
  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    resp_valid |=> !resp_valid); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_valid || resp_valid) |-> !req_ready); // R10
  AST_RESP_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (resp_valid && !resp_abort) |-> $past(bus_valid)); // R10
endmodule

// File: tb/sim_lsu_align_endian.sv
module sim_lsu_align_endian;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        cfg_align_chk = 1'b0, cfg_unal_en = 1'b0, cfg_big_end = 1'b0;
  logic        req_ready, bus_valid, bus_write, resp_valid, resp_abort;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic [3:0]  bus_strb;
  logic [63:0] resp_data;

  int checks = 0;
  int errors = 0;
  int cycle_cnt = 0;

  logic [31:0] mem [16];

  logic [63:0] got_data;
  logic        got_abort;
  int          got_beats, got_cyc;
  logic [31:0] beat_addr [2];
  logic [3:0]  beat_strb [2];

  lsu_align_endian u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_store, .req_size, .req_signed,
    .req_addr, .req_wdata, .cfg_align_chk, .cfg_unal_en, .cfg_big_end,
    .bus_valid, .bus_write, .bus_addr, .bus_strb, .bus_wdata, .bus_rdata,
    .resp_valid, .resp_abort, .resp_data
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bus memory: read data one cycle after the beat, byte strobes on writes
  always @(posedge clk) begin
    if (bus_valid) begin
      bus_rdata <= mem[bus_addr[5:2]];
      if (bus_write)
        for (int b = 0; b < 4; b++)
          if (bus_strb[b]) mem[bus_addr[5:2]][8*b +: 8] <= bus_wdata[8*b +: 8];
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cycle_cnt <= cycle_cnt + 1;
    if (cycle_cnt == WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL R10 watchdog: actual %0d cycles expected fewer", cycle_cnt);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic st, input logic [1:0] sz, input logic sg,
                        input logic [31:0] a, input logic [63:0] wd,
                        input logic ac, input logic ue, input logic be);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg;
    req_addr = a; req_wdata = wd;
    cfg_align_chk = ac; cfg_unal_en = ue; cfg_big_end = be;
    got_beats = 0; got_cyc = 0; got_abort = 1'b0; got_data = '0;
    beat_addr[0] = '0; beat_addr[1] = '0; beat_strb[0] = '0; beat_strb[1] = '0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 1; c <= 6; c++) begin
      if (bus_valid) begin
        if (got_beats < 2) begin
          beat_addr[got_beats] = bus_addr;
          beat_strb[got_beats] = bus_strb;
        end
        got_beats++;
      end
      if (resp_valid) begin
        got_cyc = c; got_abort = resp_abort; got_data = resp_data;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic ld(input logic [1:0] sz, input logic sg, input logic [31:0] a,
                    input logic ac, input logic ue, input logic be);
    access(1'b0, sz, sg, a, 64'd0, ac, ue, be);
  endtask

  task automatic t_reset();
    chk("R1 ready in reset", {63'd0, req_ready}, 64'd1);
    chk("R1 no beat in reset", {63'd0, bus_valid}, 64'd0);
    chk("R1 no resp in reset", {63'd0, resp_valid}, 64'd0);
  endtask

  task automatic t_aligned();
    ld(2'd2, 1'b0, 32'h04, 1'b0, 1'b0, 1'b0);
    chk("R11 aligned word data", got_data, 64'h00000000_A7A6A5A4);
    chk("R11 aligned word strb", {60'd0, beat_strb[0]}, 64'hF);
    chk("R10 one beat resp cycle", 64'(got_cyc), 64'd2);
    ld(2'd0, 1'b1, 32'h06, 1'b1, 1'b0, 1'b0);
    chk("R9 signed byte", got_data, 64'h00000000_FFFFFFA6);
    chk("R11 byte strb lane 2", {60'd0, beat_strb[0]}, 64'h4);
    ld(2'd0, 1'b0, 32'h06, 1'b0, 1'b0, 1'b0);
    chk("R9 unsigned byte", got_data, 64'h00000000_000000A6);
    ld(2'd1, 1'b0, 32'h02, 1'b0, 1'b0, 1'b0);
    chk("R11 half strb lanes 2,3", {60'd0, beat_strb[0]}, 64'hC);
  endtask

  task automatic t_endian();
    ld(2'd2, 1'b0, 32'h04, 1'b0, 1'b0, 1'b1);
    chk("R8 big word", got_data, 64'h00000000_A4A5A6A7);
    ld(2'd1, 1'b0, 32'h02, 1'b0, 1'b0, 1'b1);
    chk("R8 big half", got_data, 64'h00000000_0000A2A3);
    ld(2'd0, 1'b0, 32'h05, 1'b0, 1'b0, 1'b1);
    chk("R8 big byte unchanged", got_data, 64'h00000000_000000A5);
  endtask

  task automatic t_legacy();
    ld(2'd2, 1'b0, 32'h05, 1'b0, 1'b0, 1'b0);
    chk("R3 legacy rotate", got_data, 64'h00000000_A4A7A6A5);
    chk("R3 legacy one beat", 64'(got_beats), 64'd1);
    chk("R3 legacy beat addr", {32'd0, beat_addr[0]}, 64'h04);
    access(1'b1, 2'd2, 1'b0, 32'h11, 64'h11223344, 1'b0, 1'b0, 1'b0);
    chk("R4 legacy store strb", {60'd0, beat_strb[0]}, 64'hF);
    chk("R4 legacy store addr", {32'd0, beat_addr[0]}, 64'h10);
    ld(2'd2, 1'b0, 32'h10, 1'b0, 1'b0, 1'b0);
    chk("R4 legacy store readback", got_data, 64'h00000000_11223344);
  endtask

  task automatic t_check_abort();
    ld(2'd2, 1'b0, 32'h05, 1'b1, 1'b1, 1'b0);
    chk("R2 word abort", {63'd0, got_abort}, 64'd1);
    chk("R2 abort no beat", 64'(got_beats), 64'd0);
    chk("R10 abort resp cycle", 64'(got_cyc), 64'd1);
    ld(2'd1, 1'b0, 32'h03, 1'b1, 1'b0, 1'b0);
    chk("R2 half abort", {63'd0, got_abort}, 64'd1);
    ld(2'd0, 1'b0, 32'h03, 1'b1, 1'b0, 1'b0);
    chk("R2 byte no abort", {got_abort, got_data[62:0]}, 64'h00000000_000000A3);
    access(1'b1, 2'd2, 1'b0, 32'h35, 64'h99999999, 1'b1, 1'b0, 1'b0);
    chk("R2 store abort", {63'd0, got_abort}, 64'd1);
    ld(2'd2, 1'b0, 32'h34, 1'b0, 1'b0, 1'b0);
    chk("R2 aborted store left memory", got_data, 64'h00000000_D7D6D5D4);
  endtask

  task automatic t_other_abort();
    ld(2'd1, 1'b0, 32'h01, 1'b0, 1'b0, 1'b0);
    chk("R5 legacy half abort", {63'd0, got_abort}, 64'd1);
    ld(2'd3, 1'b0, 32'h02, 1'b0, 1'b1, 1'b0);
    chk("R5 dword unaligned abort", {63'd0, got_abort}, 64'd1);
    chk("R5 dword abort no beat", 64'(got_beats), 64'd0);
  endtask

  task automatic t_unaligned();
    ld(2'd2, 1'b0, 32'h06, 1'b0, 1'b1, 1'b0);
    chk("R6 split word data", got_data, 64'h00000000_A9A8A7A6);
    chk("R6 two beats", 64'(got_beats), 64'd2);
    chk("R6 beat addrs", {beat_addr[1], beat_addr[0]}, {32'h08, 32'h04});
    chk("R7 load strobes", {56'd0, beat_strb[1], beat_strb[0]}, 64'h3C);
    chk("R10 two beat resp cycle", 64'(got_cyc), 64'd3);
    ld(2'd1, 1'b1, 32'h03, 1'b0, 1'b1, 1'b0);
    chk("R6 split half signed", got_data, 64'h00000000_FFFFA4A3);
    ld(2'd1, 1'b0, 32'h01, 1'b0, 1'b1, 1'b0);
    chk("R6 inner half data", got_data, 64'h00000000_0000A2A1);
    chk("R6 inner half one beat", 64'(got_beats), 64'd1);
    ld(2'd2, 1'b0, 32'h06, 1'b0, 1'b1, 1'b1);
    chk("R8 big split word", got_data, 64'h00000000_A6A7A8A9);
  endtask

  task automatic t_dword();
    ld(2'd3, 1'b0, 32'h08, 1'b0, 1'b0, 1'b0);
    chk("R11 dword little", got_data, 64'hAFAEADAC_ABAAA9A8);
    ld(2'd3, 1'b0, 32'h08, 1'b0, 1'b0, 1'b1);
    chk("R8 dword big", got_data, 64'hACADAEAF_A8A9AAAB);
    access(1'b1, 2'd3, 1'b0, 32'h38, 64'h01020304_05060708, 1'b0, 1'b0, 1'b0);
    ld(2'd3, 1'b0, 32'h38, 1'b0, 1'b0, 1'b0);
    chk("R11 dword store readback", got_data, 64'h01020304_05060708);
  endtask

  task automatic t_stores();
    access(1'b1, 2'd2, 1'b0, 32'h21, 64'h55667788, 1'b0, 1'b1, 1'b0);
    chk("R7 split store strobes", {56'd0, beat_strb[1], beat_strb[0]}, 64'h1E);
    chk("R6 split store addrs", {beat_addr[1], beat_addr[0]}, {32'h24, 32'h20});
    ld(2'd2, 1'b0, 32'h20, 1'b0, 1'b0, 1'b0);
    chk("R7 store low word", got_data, 64'h00000000_667788C0);
    ld(2'd2, 1'b0, 32'h24, 1'b0, 1'b0, 1'b0);
    chk("R7 store high word", got_data, 64'h00000000_C7C6C555);
    access(1'b1, 2'd1, 1'b0, 32'h2A, 64'hBEEF, 1'b0, 1'b0, 1'b1);
    chk("R11 half store strb", {60'd0, beat_strb[0]}, 64'hC);
    ld(2'd2, 1'b0, 32'h28, 1'b0, 1'b0, 1'b0);
    chk("R8 big half store", got_data, 64'h00000000_EFBEC9C8);
    access(1'b1, 2'd0, 1'b0, 32'h31, 64'h5A, 1'b0, 1'b0, 1'b1);
    ld(2'd2, 1'b0, 32'h30, 1'b0, 1'b0, 1'b0);
    chk("R8 big byte store", got_data, 64'h00000000_D3D25AD0);
  endtask

  task automatic t_sign_after_swap();
    access(1'b1, 2'd0, 1'b0, 32'h12, 64'h80, 1'b0, 1'b0, 1'b0);
    ld(2'd1, 1'b1, 32'h12, 1'b0, 1'b0, 1'b0);
    chk("R9 little half positive", got_data, 64'h00000000_00001180);
    ld(2'd1, 1'b1, 32'h12, 1'b0, 1'b0, 1'b1);
    chk("R9 big half negative", got_data, 64'h00000000_FFFF8011);
  endtask

  initial begin
    for (int w = 0; w < 16; w++)
      for (int b = 0; b < 4; b++)
        mem[w][8*b +: 8] = 8'(8'hA0 + 4*w + b);
    #(CLK_PERIOD * 2);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_aligned();
    t_endian();
    t_legacy();
    t_check_abort();
    t_other_abort();
    t_unaligned();
    t_dword();
    t_stores();
    t_sign_after_swap();
    summary();
    $finish;
  end
endmodule